// File: doc/BRIEF.md
# Serial Memory Write-Protection Controller

This block keeps the protection settings of a serial memory's status byte and rules on each write request made to the memory. A request either targets the status byte or targets one byte address of the storage array. The block answers every request one cycle later with a grant or a refusal. The block also applies a granted status write to its own protection settings.

Two block-protect bits select how much of the top of the array is read-only. The choices are none, the top quarter, the top half, or the whole array. A protect-enable bit works together with an active-low external write-protect pin. When the bit is set and the pin is held low, the status byte is locked. The array outside the protected region stays writable.

A write-enable latch gates every request. A separate command pulse sets the latch. Any request clears it, whether that request is granted or refused. The status byte is presented continuously so that a serial front end can shift it out on a status read.

Top module: `wp_ctrl`

## Requirements
- R1: After a synchronous reset the status byte reads 0x00 and no response is signalled.
- R2: A pulse on `wel_set` makes status bit 1 (the write-enable latch) read 1 from the following cycle.
- R3: While the write-enable latch is 0, every request is refused, to the status byte or to any array address, and the status byte is left unchanged.
- R4: Block-protect level = status bits 3:2. Level 0 protects nothing. Level 1 protects addresses from 3/4 of the array size to the top (0x6000–0x7FFF for 32 KiB). Level 2 protects the upper half (0x4000–0x7FFF). Level 3 protects every address.
- R5: An array write to an address inside the protected region is refused whatever the pin level and the protect-enable bit.
- R6: With protect-enable (status bit 7) at 1 and `wp_n` low, status writes are refused, and array writes outside the protected region are granted when the latch is set.
- R7: With `wp_n` high, a status write with the latch set is granted even when protect-enable is 1, so the bit can be cleared.
- R8: With protect-enable at 0, a status write with the latch set is granted even when `wp_n` is low.
- R9: While protect-enable is 1 and `wp_n` stays low, protect-enable remains 1.
- R10: Any request, granted or refused, leaves the write-enable latch at 0 in the following cycle.
- R11: A granted status write copies data bit 7 to protect-enable and data bits 3:2 to the level. Every other data bit is ignored, and status bits 6:4 and 0 always read 0.
- R12: `resp_valid` is high for exactly the one cycle after each request cycle. `resp_grant` is only high together with `resp_valid`.
- R13: When `wel_set` and a request arrive in the same cycle, the request is judged on the latch value held before that cycle, and the latch ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wel_set | input | 1 | Set-write-enable command pulse |
| req_valid | input | 1 | Write request strobe, one cycle per request |
| req_is_status | input | 1 | 1: request targets the status byte; 0: the array |
| req_addr | input | ADDR_W | Array byte address of the request |
| req_wdata | input | 8 | New status byte for a status write |
| wp_n | input | 1 | External write-protect pin, active low |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_grant | output | 1 | 1: write allowed; 0: refused |
| status | output | 8 | Status byte: bit 7 protect-enable, bits 3:2 level, bit 1 latch |

## Verification
The bench builds the block with the default `ADDR_W` of 15, a 32 KiB array. With that width, the exact region edges can be probed directly: 0x5FFF and 0x6000 for the quarter level, 0x3FFF and 0x4000 for the half level, and 0x0000 and 0x7FFF at the extremes. The tests walk protect-enable and the pin through all four combinations. They try to clear protect-enable while the pin is held low. They also issue a latch-set command in the same cycle as a request.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int STAT_W       = 8;
  localparam int STAT_PEN_BIT = 7;
  localparam int STAT_LVL_HI  = 3;
  localparam int STAT_LVL_LO  = 2;
  localparam int STAT_WEL_BIT = 1;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_QTR  = 2'd1,
    LVL_HALF = 2'd2,
    LVL_ALL  = 2'd3
  } prot_lvl_e;

  typedef struct packed {
    logic      pen;
    prot_lvl_e lvl;
  } prot_cfg_t;
endpackage

// File: rtl/wp_region_chk.sv
module wp_region_chk #(
  parameter int ADDR_W = 15
) (
  input  wp_pkg::prot_lvl_e  lvl,
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit
);
  import wp_pkg::*;

  localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] QTR_BASE  = HALF_BASE | (ADDR_W'(1) << (ADDR_W - 2));

  always_comb begin
    unique case (lvl)
      LVL_NONE: hit = 1'b0;
      LVL_QTR:  hit = (addr >= QTR_BASE);
      LVL_HALF: hit = (addr >= HALF_BASE);
      default:  hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_wel.sv
module wp_wel (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  logic wel_q;

  always_ff @(posedge clk) begin
    if (rst)        wel_q <= 1'b0;
    else if (clr_i) wel_q <= 1'b0;
    else if (set_i) wel_q <= 1'b1;
  end

  assign wel_o = wel_q;

  // R10 R13
  wel_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !wel_o);

  // R2
  wel_set_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i) |=> wel_o);
endmodule

// File: rtl/wp_cfg_reg.sv
module wp_cfg_reg (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [wp_pkg::STAT_W-1:0]  wdata,
  input  logic                       wp_n,
  output wp_pkg::prot_cfg_t          cfg_o
);
  import wp_pkg::*;

  prot_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '{pen: 1'b0, lvl: LVL_NONE};
    end else if (wr_en) begin
      cfg_q.pen <= wdata[STAT_PEN_BIT];
      cfg_q.lvl <= prot_lvl_e'(wdata[STAT_LVL_HI:STAT_LVL_LO]);
    end
  end

  assign cfg_o = cfg_q;

  // R9
  pen_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.pen && !wp_n) |=> cfg_q.pen);
endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wel_set,
  input  logic              req_valid,
  input  logic              req_is_status,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  input  logic              wp_n,
  output logic              resp_valid,
  output logic              resp_grant,
  output logic [7:0]        status
);
  import wp_pkg::*;

  prot_cfg_t cfg;
  logic      wel;
  logic      region_hit;
  logic      hw_lock;
  logic      allow;
  logic      cfg_wr;
  logic      rv_q, rg_q;

  wp_wel u_wel (
    .clk   (clk),
    .rst   (rst),
    .set_i (wel_set),
    .clr_i (req_valid),
    .wel_o (wel)
  );

  wp_region_chk #(.ADDR_W(ADDR_W)) u_region (
    .lvl  (cfg.lvl),
    .addr (req_addr),
    .hit  (region_hit)
  );

  assign hw_lock = cfg.pen & ~wp_n;

  always_comb begin
    if (req_is_status) allow = wel & ~hw_lock;
    else               allow = wel & ~region_hit;
  end

  assign cfg_wr = req_valid & req_is_status & allow;

  wp_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .wr_en (cfg_wr),
    .wdata (req_wdata),
    .wp_n  (wp_n),
    .cfg_o (cfg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rv_q <= 1'b0;
      rg_q <= 1'b0;
    end else begin
      rv_q <= req_valid;
      rg_q <= req_valid & allow;
    end
  end

  assign resp_valid = rv_q;
  assign resp_grant = rg_q;

  always_comb begin
    status                          = '0;
    status[STAT_PEN_BIT]            = cfg.pen;
    status[STAT_LVL_HI:STAT_LVL_LO] = cfg.lvl;
    status[STAT_WEL_BIT]            = wel;
  end

  // R12
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);

  // R12
  resp_single_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !resp_valid);

  // R12
  grant_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    resp_grant |-> resp_valid);

  // R3
  no_wel_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !status[STAT_WEL_BIT]) |=> !resp_grant);

  // R5
  region_refused_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_is_status && region_hit) |=> !resp_grant);

  // R6
  locked_status_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_status && status[STAT_PEN_BIT] && !wp_n) |=> (!resp_grant && $stable(status[7:2])));

  // R11
  spare_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (status[6:4] == 3'b000) && !status[0]);
endmodule

// File: tb/wp_ctrl_bench.sv
module wp_ctrl_bench;
  localparam int ADDR_W = 15;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wel_set = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_is_status = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [7:0]        req_wdata = '0;
  logic              wp_n = 1'b1;
  logic              resp_valid, resp_grant;
  logic [7:0]        status;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  wp_ctrl #(.ADDR_W(ADDR_W)) u_wp_ctrl (
    .clk(clk), .rst(rst), .wel_set(wel_set), .req_valid(req_valid),
    .req_is_status(req_is_status), .req_addr(req_addr), .req_wdata(req_wdata),
    .wp_n(wp_n), .resp_valid(resp_valid), .resp_grant(resp_grant), .status(status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic set_wel();
    @(negedge clk) wel_set = 1'b1;
    @(negedge clk) wel_set = 1'b0;
  endtask

  // one request; returns grant, checks the one-cycle response (R12)
  task automatic do_req(input bit is_st, input logic [ADDR_W-1:0] a,
                        input logic [7:0] d, output logic g);
    @(negedge clk);
    req_valid = 1'b1; req_is_status = is_st; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 resp_valid after request", resp_valid, 1);
    g = resp_grant;
    chk("R10 latch cleared after request", status[1], 0);
    @(negedge clk);
    chk("R12 resp_valid drops", resp_valid, 0);
  endtask

  task automatic wr_status(input logic [7:0] d, output logic g);
    set_wel();
    do_req(1'b1, '0, d, g);
  endtask

  task automatic t_reset();
    chk("R1 status after reset", status, 8'h00);
    chk("R1 no response after reset", resp_valid, 0);
  endtask

  task automatic t_wel();
    logic g;
    set_wel();
    chk("R2 latch set", status, 8'h02);
    do_req(1'b0, 15'h0100, 8'h00, g);
    chk("R10 granted array write", g, 1);
  endtask

  task automatic t_no_wel();
    logic g;
    do_req(1'b0, 15'h0000, 8'h00, g);
    chk("R3 array write without latch", g, 0);
    do_req(1'b1, '0, 8'h8C, g);
    chk("R3 status write without latch", g, 0);
    chk("R3 status unchanged", status, 8'h00);
  endtask

  task automatic probe(input string tag, input logic [ADDR_W-1:0] a, input logic exp);
    logic g;
    set_wel();
    do_req(1'b0, a, 8'h00, g);
    chk(tag, g, exp);
  endtask

  task automatic t_levels();
    logic g;
    wp_n = 1'b1;
    probe("R4 level0 top address", 15'h7FFF, 1);
    wr_status(8'h04, g);
    chk("R4 level1 programmed", status, 8'h04);
    probe("R4 level1 below edge", 15'h5FFF, 1);
    probe("R4 level1 at edge", 15'h6000, 0);
    probe("R4 level1 top", 15'h7FFF, 0);
    wr_status(8'h08, g);
    probe("R4 level2 below edge", 15'h3FFF, 1);
    probe("R4 level2 at edge", 15'h4000, 0);
    wr_status(8'h0C, g);
    probe("R4 level3 address zero", 15'h0000, 0);
    wp_n = 1'b0;
    probe("R5 level3 with pin low", 15'h1234, 0);
    wp_n = 1'b1;
    wr_status(8'h00, g);
    chk("R4 back to level0", status, 8'h00);
  endtask

  task automatic t_hw();
    logic g;
    wp_n = 1'b1;
    wr_status(8'h84, g);
    chk("R7 enable bit write with pin high", g, 1);
    chk("R7 status programmed", status, 8'h84);
    wp_n = 1'b0;
    wr_status(8'h00, g);
    chk("R6 status write while locked", g, 0);
    chk("R9 enable bit held while pin low", status, 8'h84);
    repeat (3) @(negedge clk);
    chk("R9 still held", status[7], 1);
    probe("R6 unprotected array while locked", 15'h1000, 1);
    probe("R5 protected array while locked", 15'h6000, 0);
    wp_n = 1'b1;
    wr_status(8'h00, g);
    chk("R7 clear with pin high", g, 1);
    chk("R7 status cleared", status, 8'h00);
    wp_n = 1'b0;
    wr_status(8'h08, g);
    chk("R8 status write enable=0 pin low", g, 1);
    chk("R8 status value", status, 8'h08);
    wp_n = 1'b1;
  endtask

  task automatic t_mask();
    logic g;
    wr_status(8'hFF, g);
    chk("R11 granted", g, 1);
    chk("R11 only bits 7,3:2 kept", status, 8'h8C);
    wr_status(8'h73, g);
    chk("R11 clear with spare bits set", status, 8'h00);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    wel_set = 1'b1; req_valid = 1'b1; req_is_status = 1'b0; req_addr = 15'h0010;
    @(negedge clk);
    wel_set = 1'b0; req_valid = 1'b0;
    chk("R13 judged on prior latch", resp_grant, 0);
    chk("R13 latch ends clear", status[1], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_wel();
    t_no_wel();
    t_levels();
    t_hw();
    t_mask();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      misses++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule